// File: doc/BRIEF.md
# Skip-Capable Phase Barrier

This block synchronises a fixed group of participants, such as the wavefronts of one work-group, through repeated barrier phases. Each participant has its own two-bit request lane and its own wake output. A participant may mark the current phase as satisfied without stalling (arrive). It may mark it satisfied and stall until the phase is complete (wait). It may also mark it satisfied and leave the group for good (skip). Because skipped participants are removed from every later phase, divergent branches and early loop exits cannot leave the barrier waiting for a participant that will never return.

A construct command loads the group size. The participants are the IDs below that size, and all per-phase state is cleared. A phase completes once every participant still in the group is satisfied. Any number of requests may arrive in the same cycle, and all of them are counted before completion is decided. On completion every stalled participant gets a wake pulse in the same cycle and a new phase begins. The scheduling of the stalled participants and memory ordering are handled outside this block.

Top module: `phase_barrier`

## Requirements
- R1: A construct command (`cfg_valid` high) with count K makes IDs 0..K-1 the participants and clears all phase state. It discards pending waiters without waking them. IDs K and above count as withdrawn. Requests presented in the same cycle as a construct are ignored and raise no fault.
- R2: The request of ID i sits in `req_op[2i+1:2i]`, encoded as 00 none, 01 arrive, 10 skip, 11 wait.
- R3: An arrive satisfies the current phase for its ID and never produces a wake pulse for that ID.
- R4: When a phase completes, `wake` carries a one-cycle pulse, in the cycle after the completing request, exactly on the IDs that issued a wait in that phase.
- R5: A skip satisfies the current phase and withdraws the ID permanently. Later phases complete without it.
- R6: A phase completes in the cycle in which every non-withdrawn ID is satisfied. All requests of that cycle are counted before this is decided. Completion clears the satisfied and waiting flags, so the barrier can be reused for any number of phases.
- R7: The following requests are ignored and give a one-cycle `fault` pulse on their ID in the next cycle: an arrive or wait from an ID already satisfied in the phase, any request from an ID that is waiting, and any request from a withdrawn ID.
- R8: After reset no ID is a participant, and `wake` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Construct command |
| cfg_count | input | $clog2(NPART+1) | Participant count for construct |
| req_op | input | 2*NPART | Per-ID request lanes |
| wake | output | NPART | Per-ID release pulse for waiters |
| fault | output | NPART | Per-ID pulse for ignored illegal requests |

## Verification
The bench builds the barrier with NPART = 8. With that value every ID can act in one cycle, and the bench can exercise a full-group construct where all eight IDs wait together. It can also reach IDs above a smaller constructed count, which checks the withdrawn-by-construction path. The sequences cover several phases in a row, shrinking the group through skips, completion caused by simultaneous requests, every fault kind, and a construct that discards a pending waiter.

// File: rtl/bar_pkg.sv
package bar_pkg;

    typedef enum logic [1:0] {
        BOP_NONE   = 2'b00,
        BOP_ARRIVE = 2'b01,
        BOP_SKIP   = 2'b10,
        BOP_WAIT   = 2'b11
    } bar_op_e;

    // Next-state contribution of one participant slot.
    typedef struct packed {
        logic sat;
        logic wt;
        logic skp;
        logic flt;
    } slot_nx_t;

    function automatic logic op_is_illegal(bar_op_e op, logic sat, logic wt, logic skp);
        if (op == BOP_NONE) return 1'b0;
        return skp | wt | (sat & (op != BOP_SKIP));
    endfunction

endpackage

// File: rtl/bar_slot.sv
module bar_slot
    import bar_pkg::*;
(
    input  bar_op_e  op_i,
    input  logic     sat_i,
    input  logic     wt_i,
    input  logic     skp_i,
    output slot_nx_t nx_o
);
    logic ill;
    logic acc;

    always_comb begin
        ill       = op_is_illegal(op_i, sat_i, wt_i, skp_i);
        acc       = (op_i != BOP_NONE) && !ill;
        nx_o.flt  = ill;
        nx_o.sat  = sat_i | acc;
        nx_o.wt   = wt_i  | (acc && (op_i == BOP_WAIT));
        nx_o.skp  = skp_i | (acc && (op_i == BOP_SKIP));
    end
endmodule

// File: rtl/bar_join.sv
module bar_join #(
    parameter int NPART = 16
) (
    input  logic [NPART-1:0] sat_i,
    input  logic [NPART-1:0] skp_i,
    output logic             done_o
);
    // Complete when no remaining participant is still unsatisfied.
    logic [NPART-1:0] pending;

    always_comb begin
        pending = ~skp_i & ~sat_i;
        done_o  = (pending == '0);
    end
endmodule

// File: rtl/phase_barrier.sv
module phase_barrier
    import bar_pkg::*;
#(
    parameter  int NPART = 16,
    localparam int CW    = $clog2(NPART + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_valid,
    input  logic [CW-1:0]      cfg_count,
    input  logic [2*NPART-1:0] req_op,
    output logic [NPART-1:0]   wake,
    output logic [NPART-1:0]   fault
);
    logic [NPART-1:0] sat_q, wt_q, skp_q;
    logic [NPART-1:0] sat_n, wt_n, skp_n, flt_n;
    logic [NPART-1:0] member;
    logic             done;

    for (genvar i = 0; i < NPART; i++) begin : g_slot
        slot_nx_t nx;
        bar_slot u_slot (
            .op_i  (bar_op_e'(req_op[2*i +: 2])),
            .sat_i (sat_q[i]),
            .wt_i  (wt_q[i]),
            .skp_i (skp_q[i]),
            .nx_o  (nx)
        );
        assign sat_n[i]  = nx.sat;
        assign wt_n[i]   = nx.wt;
        assign skp_n[i]  = nx.skp;
        assign flt_n[i]  = nx.flt;
        assign member[i] = (CW'(i) < cfg_count);
    end

    bar_join #(.NPART(NPART)) u_join (
        .sat_i  (sat_n),
        .skp_i  (skp_n),
        .done_o (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sat_q <= '0;
            wt_q  <= '0;
            skp_q <= '1;
            wake  <= '0;
            fault <= '0;
        end else if (cfg_valid) begin
            sat_q <= '0;
            wt_q  <= '0;
            skp_q <= ~member;
            wake  <= '0;
            fault <= '0;
        end else begin
            fault <= flt_n;
            skp_q <= skp_n;
            if (done) begin
                wake  <= wt_n;
                sat_q <= '0;
                wt_q  <= '0;
            end else begin
                wake  <= '0;
                sat_q <= sat_n;
                wt_q  <= wt_n;
            end
        end
    end

    // A stalled participant must always be counted as satisfied (R4).
    p_wait_implies_sat_r4: assert property (@(posedge clk) disable iff (rst)
        (wt_q & ~sat_q) == '0);

    // A wake pulse only goes to IDs that were waiting or asked to wait (R4).
    p_wake_only_waiters_r4: assert property (@(posedge clk) disable iff (rst)
        (wake & ~$past(wt_n)) == '0);

    // Withdrawal is permanent outside a construct (R5).
    p_skip_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_valid) |-> (($past(skp_q) & ~skp_q) == '0));

    // A wake means the phase just restarted with clear flags (R6).
    p_wake_clears_phase_r6: assert property (@(posedge clk) disable iff (rst)
        (|wake) |-> (sat_q == '0 && wt_q == '0));

    // Requests beside a construct raise no fault (R1).
    p_cfg_no_fault_r1: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_valid) |-> (fault == '0));

endmodule

// File: tb/phase_barrier_tb_top.sv
module phase_barrier_tb_top;
    localparam int N  = 8;
    localparam int CW = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst;
    logic            cfg_valid;
    logic [CW-1:0]   cfg_count;
    logic [2*N-1:0]  req_op;
    logic [N-1:0]    wake;
    logic [N-1:0]    fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [N-1:0] q_wake[$];
    logic [N-1:0] q_flt[$];
    string        q_tag[$];

    always #4 clk = ~clk;

    phase_barrier #(.NPART(N)) dut_i (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_count(cfg_count),
        .req_op(req_op), .wake(wake), .fault(fault)
    );

    localparam logic [1:0] AR = 2'b01, SK = 2'b10, WT = 2'b11;

    function automatic logic [2*N-1:0] op1(int id, logic [1:0] op);
        logic [2*N-1:0] v = '0;
        v[2*id +: 2] = op;
        return v;
    endfunction

    task automatic step(input logic c, input int cnt, input logic [2*N-1:0] ops,
                        input logic [N-1:0] ew, input logic [N-1:0] ef, input string tag);
        @(negedge clk);
        cfg_valid = c;
        cfg_count = CW'(cnt);
        req_op    = ops;
        q_wake.push_back(ew);
        q_flt.push_back(ef);
        q_tag.push_back(tag);
    endtask

    // Monitor: compares after each edge against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_tag.size() > 0) begin
                logic [N-1:0] ew, ef;
                string t;
                ew = q_wake.pop_front();
                ef = q_flt.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (wake !== ew || fault !== ef) begin
                    errors++;
                    $display("FAIL %s: wake=%b fault=%b expected wake=%b fault=%b",
                             t, wake, fault, ew, ef);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_valid = 1'b0; cfg_count = '0; req_op = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (wake !== '0 || fault !== '0) begin
            errors++;
            $display("FAIL R8 reset: wake=%b fault=%b expected 0 0", wake, fault);
        end
        // R8: no participants before construct
        step(0, 0, op1(0, AR), 8'h00, 8'h01, "R8 pre-construct arrive");
        // R1 construct of four
        step(1, 4, '0, 8'h00, 8'h00, "R1 construct 4");
        // R2 R3 R4 R6 first phase
        step(0, 0, op1(0, WT) | op1(1, AR), 8'h00, 8'h00, "R4 wait held");
        step(0, 0, op1(2, AR), 8'h00, 8'h00, "R3 arrive no wake");
        step(0, 0, op1(3, AR), 8'h01, 8'h00, "R4 R6 completion wakes waiter");
        // R5 R6 simultaneous requests incl skip
        step(0, 0, op1(0, AR) | op1(1, AR) | op1(2, WT) | op1(3, SK), 8'h04, 8'h00,
             "R6 same-cycle completion");
        // R5 smaller group
        step(0, 0, op1(0, WT) | op1(1, WT), 8'h00, 8'h00, "R5 waiters held");
        step(0, 0, op1(2, AR), 8'h03, 8'h00, "R5 completes without skipped");
        // R7 fault cases
        step(0, 0, op1(3, AR), 8'h00, 8'h08, "R7 skipped id");
        step(0, 0, op1(0, AR), 8'h00, 8'h00, "R3 arrive");
        step(0, 0, op1(0, WT), 8'h00, 8'h01, "R7 repeat after arrive");
        step(0, 0, op1(4, AR), 8'h00, 8'h10, "R1 non-member id");
        step(0, 0, op1(1, WT), 8'h00, 8'h00, "R4 wait held");
        step(0, 0, op1(1, WT), 8'h00, 8'h02, "R7 request while waiting");
        step(0, 0, op1(2, SK), 8'h02, 8'h00, "R5 skip completes phase");
        // R1 construct discards pending waiter
        step(0, 0, op1(0, WT), 8'h00, 8'h00, "R4 waiter before construct");
        step(1, 2, '0, 8'h00, 8'h00, "R1 construct 2");
        step(0, 0, op1(0, AR) | op1(1, AR), 8'h00, 8'h00, "R1 old waiter dropped");
        step(0, 0, op1(0, WT) | op1(1, AR), 8'h01, 8'h00, "R6 reuse after construct");
        // R1 requests beside construct ignored
        step(1, 3, op1(0, WT), 8'h00, 8'h00, "R1 construct with request");
        step(0, 0, op1(1, AR) | op1(2, AR), 8'h00, 8'h00, "R1 id0 still pending");
        step(0, 0, op1(0, WT), 8'h01, 8'h00, "R1 id0 completes");
        // full group
        step(1, 8, '0, 8'h00, 8'h00, "R1 construct 8");
        step(0, 0, {N{WT}}, 8'hFF, 8'h00, "R6 all wait together");
        step(0, 0, {N{AR}}, 8'h00, 8'h00, "R3 all arrive");
        // empty group
        step(1, 0, '0, 8'h00, 8'h00, "R1 construct 0");
        step(0, 0, op1(0, WT), 8'h00, 8'h01, "R1 empty group fault");
        step(0, 0, '0, 8'h00, 8'h00, "idle");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule